// File: doc/BRIEF.md
# Adjacent-Flip Tolerant Protected Word Memory

This block sits around a synchronous single-port word memory and guards every stored word against soft upsets. On a write, the 32-bit data word is split into two 16-bit lanes. Each lane gets its own extended Hamming code: 5 position-parity bits plus one overall parity bit, giving 22 bits per lane. The two 22-bit lane codewords are then interleaved bit by bit into one 44-bit stored word. Stored bit `2*j` holds bit `j` of the low lane codeword, and stored bit `2*j+1` holds bit `j` of the high lane codeword. Because of this layout, any two physically neighbouring stored bits belong to different lanes.

On a read, the stored word is taken apart into its two lanes. Each lane is decoded and repaired independently, and the corrected 32-bit word is returned together with three status flags. Lane codeword bit 0 is the overall parity. Codeword bits at positions 1, 2, 4, 8 and 16 are the position-parity bits. The 16 data bits occupy the remaining positions 3..21 in ascending order.

Data moves over valid/ready handshakes. A write is taken in every cycle its valid is high. A read request is taken only when no write is offered and the response slot is free, or is being emptied in that same cycle. A response, once valid, stays unchanged until the consumer accepts it with ready. A test input, `inj_mask`, is XORed into the 44-bit stored word as it is written, so that upsets can be planted on purpose.

Top module: `adj_ecc_ram`

## Requirements
- R1: A write is accepted in every cycle (`wr_ready` is 1). A later read of that address returns the written data with all three flags low, provided the write used an all-zero `inj_mask`.
- R2: A read request accepted at a clock edge produces `rsp_valid` high right after that edge. The response carries the data and flags.
- R3: A single flipped stored bit at any of the 44 positions, check bits included, is repaired. The response shows the original data with only `stat_corr_single` set.
- R4: Two flips at adjacent stored positions `j` and `j+1` are repaired. The response shows the original data with only `stat_corr_double` set (one repaired error in each lane).
- R5: Three flips at adjacent stored positions `j..j+2` put two errors into one lane. The response shows only `stat_uncorr` set.
- R6: While `wr_valid` is high, `rd_req_ready` is low and no read is taken. A read held through the write is taken in the next free cycle and returns the just-written word.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response data and flags stay stable and `rd_req_ready` is low.
- R8: At most one status flag is high at any time, and all flags are low while `rsp_valid` is low.
- R9: After reset, `rsp_valid` and all flags are low, and both `wr_ready` and `rd_req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write taken (always high) |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 32 | Write data |
| inj_mask | input | 44 | Bits XORed into the stored word on write (test use) |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read request taken |
| rd_addr | input | 6 | Read word address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Corrected read data |
| stat_corr_single | output | 1 | One error repaired |
| stat_corr_double | output | 1 | Two errors repaired, one per lane |
| stat_uncorr | output | 1 | Error found that cannot be repaired |

## Verification
A write and a read request can be offered in the same cycle. They then compete for the single memory port, and a held response can also block a new request at the same moment. The bench raises `wr_valid` and `rd_req_valid` together on one address and expects `rd_req_ready` to be low while the write is offered. It then expects the read to go through one cycle later and return the freshly written word. It also holds `rsp_ready` low while a second request waits, and judges that the first response stays frozen. The waiting request must then be taken in the very cycle the held response is accepted.

// File: rtl/adj_ecc_pkg.sv
package adj_ecc_pkg;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // number of position-parity bits for a lane of dw data bits
  function automatic int hamming_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  function automatic int lane_cw_width(input int dw);
    return dw + hamming_bits(dw) + 1;
  endfunction

  // codeword position holding data bit k
  function automatic int data_slot(input int k);
    int n;
    n = 0;
    for (int i = 1; i < 64; i++) begin
      if (!is_pow2(i)) begin
        if (n == k) return i;
        n++;
      end
    end
    return 0;
  endfunction

  // data bit index held at a non-parity codeword position
  function automatic int data_index(input int pos);
    int n;
    n = 0;
    for (int i = 1; i < 64; i++) begin
      if (i < pos && !is_pow2(i)) n++;
    end
    return n;
  endfunction

  // codeword positions covered by syndrome bit k
  function automatic logic [63:0] cover_mask(input int k);
    logic [63:0] m;
    m = '0;
    for (int i = 1; i < 64; i++) m[i] = ((i >> k) & 1) == 1;
    return m;
  endfunction

  // data bits feeding parity bit k
  function automatic logic [63:0] data_mask(input int k, input int dw);
    logic [63:0] m;
    m = '0;
    for (int d = 0; d < 64; d++) begin
      if (d < dw) m[d] = ((data_slot(d) >> k) & 1) == 1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_lane_enc.sv
module ecc_lane_enc #(
  parameter int DW = 16,
  localparam int PW = adj_ecc_pkg::hamming_bits(DW),
  localparam int CW = DW + PW + 1
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] cw
);
  logic [PW-1:0] par;
  logic [CW-1:1] body;

  for (genvar k = 0; k < PW; k++) begin : g_par
    localparam logic [63:0] DM = adj_ecc_pkg::data_mask(k, DW);
    assign par[k] = ^(data & DM[DW-1:0]);
  end

  for (genvar i = 1; i < CW; i++) begin : g_pos
    if (adj_ecc_pkg::is_pow2(i)) begin : g_p
      assign body[i] = par[$clog2(i)];
    end else begin : g_d
      assign body[i] = data[adj_ecc_pkg::data_index(i)];
    end
  end

  // overall parity sits at position 0 so the full codeword has even parity
  assign cw = {body, ^body};
endmodule

// File: rtl/ecc_lane_dec.sv
module ecc_lane_dec #(
  parameter int DW = 16,
  localparam int PW = adj_ecc_pkg::hamming_bits(DW),
  localparam int CW = DW + PW + 1
) (
  input  logic [CW-1:0] cw,
  output logic [DW-1:0] data,
  output logic          corrected,
  output logic          uncorr
);
  logic [PW-1:0] syn;
  logic          ovr;
  logic          in_range;
  logic [CW-1:0] flip;
  logic [CW-1:0] fixed;

  for (genvar k = 0; k < PW; k++) begin : g_syn
    localparam logic [63:0] CM = adj_ecc_pkg::cover_mask(k);
    assign syn[k] = ^(cw & CM[CW-1:0]);
  end

  assign ovr      = ^cw;
  assign in_range = (int'(syn) < CW);
  // odd parity => one flip at position syn (syn==0 is the overall bit)
  assign flip     = (ovr && in_range) ? ({{(CW-1){1'b0}}, 1'b1} << syn) : '0;
  assign fixed    = cw ^ flip;

  assign corrected = ovr && in_range;
  assign uncorr    = (ovr && !in_range) || (!ovr && (syn != '0));

  for (genvar k = 0; k < DW; k++) begin : g_out
    assign data[k] = fixed[adj_ecc_pkg::data_slot(k)];
  end
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store #(
  parameter int W  = 44,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  // single port: write and read never share a cycle
  assert_port_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));
endmodule

// File: rtl/adj_ecc_ram.sv
module adj_ecc_ram #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int ADDR_W = 6,
  localparam int LANES = DATA_W / LANE_W,
  localparam int CW_W  = adj_ecc_pkg::lane_cw_width(LANE_W),
  localparam int ST_W  = CW_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ST_W-1:0]   inj_mask,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              stat_corr_single,
  output logic              stat_corr_double,
  output logic              stat_uncorr
);
  logic [LANES-1:0][CW_W-1:0] enc_cw;
  logic [LANES-1:0][CW_W-1:0] rd_cw;
  logic [ST_W-1:0]            st_wdata;
  logic [ST_W-1:0]            st_rdata;
  logic [LANES-1:0]           lane_corr;
  logic [LANES-1:0]           lane_unc;
  logic [ADDR_W-1:0]          port_addr;
  logic                       rd_fire;
  logic                       any_unc;

  // handshake: writes always win the port
  assign wr_ready     = 1'b1;
  assign rd_req_ready = !wr_valid && (!rsp_valid || rsp_ready);
  assign rd_fire      = rd_req_valid && rd_req_ready;
  assign port_addr    = wr_valid ? wr_addr : rd_addr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ecc_lane_enc #(.DW(LANE_W)) u_enc (
      .data (wr_data[l*LANE_W +: LANE_W]),
      .cw   (enc_cw[l])
    );
    for (genvar j = 0; j < CW_W; j++) begin : g_bit
      assign st_wdata[j*LANES + l] = enc_cw[l][j];
      assign rd_cw[l][j]           = st_rdata[j*LANES + l];
    end
    ecc_lane_dec #(.DW(LANE_W)) u_dec (
      .cw        (rd_cw[l]),
      .data      (rsp_data[l*LANE_W +: LANE_W]),
      .corrected (lane_corr[l]),
      .uncorr    (lane_unc[l])
    );
  end

  ecc_word_store #(.W(ST_W), .AW(ADDR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_valid),
    .re    (rd_fire),
    .addr  (port_addr),
    .wdata (st_wdata ^ inj_mask),
    .rdata (st_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         rsp_valid <= 1'b0;
    else if (rd_fire)   rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;
  end

  assign any_unc          = |lane_unc;
  assign stat_uncorr      = rsp_valid && any_unc;
  assign stat_corr_single = rsp_valid && !any_unc && ($countones(lane_corr) == 1);
  assign stat_corr_double = rsp_valid && !any_unc && ($countones(lane_corr) == 2);

  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
      $stable({stat_corr_single, stat_corr_double, stat_uncorr})));

  assert_rsp_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_req_ready);

  assert_flag_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_corr_single, stat_corr_double, stat_uncorr}));
endmodule

// File: tb/tb_adj_ecc_ram.sv
module tb_adj_ecc_ram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ready;
  logic [5:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rsp_data;
  logic [43:0] inj_mask;
  logic        rd_req_valid, rd_req_ready;
  logic        rsp_valid, rsp_ready;
  logic        stat_corr_single, stat_corr_double, stat_uncorr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adj_ecc_ram dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .inj_mask(inj_mask),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .stat_corr_single(stat_corr_single), .stat_corr_double(stat_corr_double),
    .stat_uncorr(stat_uncorr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {uncorr, double, single}: even stored bits -> low lane, odd -> high lane
  function automatic logic [2:0] exp_flags(input logic [43:0] m);
    int c0, c1;
    c0 = 0; c1 = 0;
    for (int i = 0; i < 44; i++) if (m[i]) begin
      if (i % 2 == 0) c0++; else c1++;
    end
    if (c0 >= 2 || c1 >= 2) return 3'b100;
    if (c0 == 1 && c1 == 1) return 3'b010;
    if (c0 + c1 == 1)       return 3'b001;
    return 3'b000;
  endfunction

  function automatic string tag_of(input logic [43:0] m);
    case (exp_flags(m))
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b100:  return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic do_write(input logic [5:0] a, input logic [31:0] d, input logic [43:0] m);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; inj_mask = m;
    @(negedge clk);
    wr_valid = 1'b0; inj_mask = '0;
  endtask

  task automatic read_check(input logic [5:0] a, input logic [31:0] d, input logic [43:0] m);
    logic [2:0] ef;
    string t;
    ef = exp_flags(m);
    t = tag_of(m);
    @(negedge clk);
    rd_req_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
    chk({stat_uncorr, stat_corr_double, stat_corr_single} == ef, {t, " flags"},
        64'({stat_uncorr, stat_corr_double, stat_corr_single}), 64'(ef));
    if (!ef[2]) chk(rsp_data == d, {t, " data"}, 64'(rsp_data), 64'(d));
  endtask

  task automatic wr_rd(input logic [5:0] a, input logic [31:0] d, input logic [43:0] m);
    do_write(a, d, m);
    read_check(a, d, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20151211);
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; inj_mask = '0;
    rd_req_valid = 1'b0; rd_addr = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(rsp_valid == 1'b0, "R9 rsp_valid", 64'(rsp_valid), 64'd0);
    chk({stat_uncorr, stat_corr_double, stat_corr_single} == 3'b000, "R9 flags",
        64'({stat_uncorr, stat_corr_double, stat_corr_single}), 64'd0);
    chk(wr_ready && rd_req_ready, "R9 ready", 64'({wr_ready, rd_req_ready}), 64'd3);

    // R1 clean words, edge data patterns
    wr_rd(6'd0,  32'h0000_0000, '0);
    wr_rd(6'd63, 32'hFFFF_FFFF, '0);
    wr_rd(6'd9,  32'hA5A5_5A5A, '0);
    // R3 single flips incl. overall parity bits (0,1), a position parity (2), top bit
    wr_rd(6'd1, 32'h1234_5678, 44'd1);
    wr_rd(6'd2, 32'h8765_4321, 44'd1 << 1);
    wr_rd(6'd3, 32'hDEAD_BEEF, 44'd1 << 2);
    wr_rd(6'd4, 32'hCAFE_F00D, 44'd1 << 43);
    // R4 adjacent pairs at both ends
    wr_rd(6'd5, 32'h0F0F_F0F0, 44'b11);
    wr_rd(6'd6, 32'h3333_CCCC, 44'b11 << 42);
    // R5 adjacent triples at both ends
    wr_rd(6'd7, 32'h5555_AAAA, 44'b111);
    wr_rd(6'd8, 32'h0123_4567, 44'b111 << 41);
    // R1: the mask hits only its own write; a clean rewrite reads clean
    wr_rd(6'd8, 32'h89AB_CDEF, '0);

    // R6: write and read offered together
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 6'd20; wr_data = 32'hBEEF_0020; inj_mask = '0;
    rd_req_valid = 1'b1; rd_addr = 6'd20;
    #1 chk(rd_req_ready == 1'b0, "R6 ready during write", 64'(rd_req_ready), 64'd0);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R6 no read with write", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rd_req_valid = 1'b0;
    chk(rsp_valid == 1'b1 && rsp_data == 32'hBEEF_0020, "R6 deferred read",
        64'(rsp_data), 64'hBEEF_0020);

    // R7: back-pressure
    do_write(6'd30, 32'h1111_2222, '0);
    do_write(6'd31, 32'h3333_4444, 44'd1 << 10);
    @(negedge clk);
    rsp_ready = 1'b0; rd_req_valid = 1'b1; rd_addr = 6'd30;
    @(negedge clk);
    rd_addr = 6'd31;
    chk(rsp_valid && rsp_data == 32'h1111_2222, "R7 first rsp", 64'(rsp_data), 64'h1111_2222);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == 32'h1111_2222 && !stat_corr_single, "R7 held rsp",
          64'(rsp_data), 64'h1111_2222);
      chk(rd_req_ready == 1'b0, "R7 stall", 64'(rd_req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rd_req_valid = 1'b0;
    chk(rsp_valid && rsp_data == 32'h3333_4444 && stat_corr_single, "R7 next rsp",
        64'(rsp_data), 64'h3333_4444);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 idle valid", 64'(rsp_valid), 64'd0);
    chk({stat_uncorr, stat_corr_double, stat_corr_single} == 3'b000, "R8 idle flags",
        64'({stat_uncorr, stat_corr_double, stat_corr_single}), 64'd0);

    // random mix
    for (int n = 0; n < 200; n++) begin
      logic [5:0]  a;
      logic [31:0] d;
      logic [43:0] m;
      int          typ, j;
      a = 6'($urandom_range(63, 0));
      d = $urandom;
      typ = int'($urandom_range(3, 0));
      case (typ)
        1: begin j = int'($urandom_range(43, 0)); m = 44'd1 << j; end
        2: begin j = int'($urandom_range(42, 0)); m = 44'b11 << j; end
        3: begin j = int'($urandom_range(41, 0)); m = 44'b111 << j; end
        default: m = '0;
      endcase
      wr_rd(a, d, m);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule